// File: doc/BRIEF.md
# Free-Running Timer with Dual Compare

A 16-bit up-counter with two output compare channels (A and B), controlled by a CPU over an 8-bit register bus. The counter advances on one of several externally supplied tick strobes, chosen by a clock select field. Each channel holds a 16-bit compare value that is checked against the counter on every clock cycle. A match raises that channel's status flag and loads a programmed level onto the channel's output pin. Channel A can also be set to clear the counter on its match. An overflow flag records each wrap of the counter.

The bus is only one byte wide, so every 16-bit register goes through a shared temporary byte. Reading the upper byte freezes the lower byte. Writing the upper byte parks it until the lower-byte write commits all 16 bits. The CPU therefore never sees or creates a torn value. A standby input puts the counter and the compare values back to their reset contents without a full reset.

Top module: `frt_dual_cmp`

## Requirements
- R1: After reset the counter is 0x0000 and both compare values are 0xFFFF. The control and status registers read 0, and both output pins are 0.
- R2: When no load, clear or standby occurs, the counter adds 1 on each cycle where tick_i[cks] is 1. Here cks is control bits [1:0]. The counter holds its value when that tick is 0.
- R3: On a wrap from 0xFFFF to 0x0000 caused by a tick, status bit 2 (overflow) is set.
- R4: With control bit 2 set, the counter goes to 0x0000 in the cycle after it equals compare A, whether or not a tick occurs.
- R5: Whenever the counter equals compare A, status bit 0 is set. Whenever it equals compare B, status bit 1 is set.
- R6: On a match the pin of that channel takes its level bit: control bit 3 for A, control bit 4 for B. The pin holds that level until the channel's next match.
- R7: Byte addresses are as follows. 0 is control and 1 is status. 2 and 3 are the counter, 4 and 5 compare A, and 6 and 7 compare B, each pair upper byte then lower byte. Reading an upper byte returns it and latches the lower byte of the same register. Reading any lower-byte address returns that latched byte.
- R8: Writing an upper-byte address stores the byte in the temporary latch. Writing a lower-byte address loads {latch, byte} into the register in one cycle. A counter load wins over a tick or a clear in the same cycle.
- R9: A status bit clears when 0 is written to it after it was read as 1. A status write without such a prior read leaves the flags unchanged. A hardware set in the same cycle wins over the clear.
- R10: While stby_i is high, the counter is forced to 0x0000 and both compare values to 0xFFFF on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stby_i | input | 1 | Standby reinitialisation request |
| tick_i | input | NUM_TICK | Candidate count strobes, one selected by cks |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while a read is selected |
| cmp_a_o | output | 1 | Channel A output pin |
| cmp_b_o | output | 1 | Channel B output pin |

## Verification
The bench builds the block with its default parameters: four tick sources and a 16-bit counter on the byte bus. With these values every clock select code can be tried. Compare values written with a zero upper byte sit close enough to the counter that matches, clears on match and pin toggles happen often during random traffic. Counter loads just below 0xFFFF bring the wrap and the overflow flag within a few cycles. Loads and standby pulses arriving at random against random ticks exercise the priority between them.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;

  // control byte bit positions above the clock select field
  localparam int CLR_A_BIT = 2;
  localparam int LVL_A_BIT = 3;
  localparam int LVL_B_BIT = 4;

  // status bit positions
  localparam int F_MATCH_A = 0;
  localparam int F_MATCH_B = 1;
  localparam int F_WRAP    = 2;
endpackage

// File: rtl/frt_bus.sv
module frt_bus
  import frt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_a_i,
  input  logic [CNT_W-1:0]  cmp_b_i,
  input  logic [BYTE_W-1:0] ctrl_rd_i,
  input  logic [BYTE_W-1:0] stat_rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [2:0]        load_o,      // {cmp_b, cmp_a, cnt}
  output logic [CNT_W-1:0]  load_val_o,
  output logic              ctrl_we_o,
  output logic              stat_we_o,
  output logic              stat_re_o
);
  logic [BYTE_W-1:0] tmp_q;
  logic [CNT_W-1:0]  word;
  logic              wide, hi, wr, rd;

  assign wr   = sel_i & we_i;
  assign rd   = sel_i & ~we_i;
  assign wide = addr_i[2:1] != 2'd0;
  assign hi   = ~addr_i[0];

  always_comb begin
    unique case (addr_i[2:1])
      2'd1:    word = cnt_i;
      2'd2:    word = cmp_a_i;
      2'd3:    word = cmp_b_i;
      default: word = '0;
    endcase
  end

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_load
      assign load_o[k] = wr & ~hi & (addr_i[2:1] == 2'(k + 1));
    end
  endgenerate

  assign load_val_o = {tmp_q, wdata_i};
  assign ctrl_we_o  = wr & (addr_i == ADR_CTRL);
  assign stat_we_o  = wr & (addr_i == ADR_STAT);
  assign stat_re_o  = rd & (addr_i == ADR_STAT);

  always_comb begin
    if (addr_i == ADR_CTRL)      rdata_o = ctrl_rd_i;
    else if (addr_i == ADR_STAT) rdata_o = stat_rd_i;
    else if (hi)                 rdata_o = word[CNT_W-1:BYTE_W];
    else                         rdata_o = tmp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tmp_q <= '0;
    else if (wide && hi && wr)   tmp_q <= wdata_i;
    else if (wide && hi && rd)   tmp_q <= word[BYTE_W-1:0];
  end

  assert_snapshot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && wide && hi) |=> tmp_q == $past(word[BYTE_W-1:0]));
  assert_park_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wide && hi) |=> tmp_q == $past(wdata_i));
endmodule

// File: rtl/frt_counter.sv
module frt_counter
  import frt_pkg::*;
#(
  parameter int NUM_TICK = 4,
  parameter int CKS_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic [CKS_W-1:0]    cks_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_val_i,
  input  logic                clr_i,
  input  logic                stby_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = tick_i[cks_i];
  assign wrap_o = step & ~load_i & ~clr_i & ~stby_i & (cnt_q == '1);
  assign cnt_o  = cnt_q;

  // priority: standby, CPU load, clear on match, tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (stby_i) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (clr_i)  cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !load_i && !clr_i && !stby_i) |=> $stable(cnt_q));
  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i && !stby_i) |=> cnt_q == '0);
  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !stby_i) |=> cnt_q == $past(load_val_i));
  assert_stby_cnt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> cnt_q == '0);
endmodule

// File: rtl/frt_cmp_ch.sv
module frt_cmp_ch
  import frt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             stby_i,
  input  logic             level_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o,
  output logic             pin_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             pin_q;

  assign cmp_o   = cmp_q;
  assign match_o = cnt_i == cmp_q;
  assign pin_o   = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '1;
    else if (stby_i) cmp_q <= '1;
    else if (load_i) cmp_q <= load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_q <= 1'b0;
    else if (match_o) pin_q <= level_i;
  end

  assert_pin_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> pin_q == $past(level_i));
  assert_pin_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |=> $stable(pin_q));
  assert_stby_cmp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> cmp_q == '1);
endmodule

// File: rtl/frt_dual_cmp.sv
module frt_dual_cmp
  import frt_pkg::*;
#(
  parameter int NUM_TICK = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stby_i,
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BYTE_W-1:0]   bus_wdata_i,
  output logic [BYTE_W-1:0]   bus_rdata_o,
  output logic                cmp_a_o,
  output logic                cmp_b_o
);
  localparam int CKS_W = (NUM_TICK > 1) ? $clog2(NUM_TICK) : 1;

  logic [CKS_W-1:0] cks_q;
  logic             clr_a_q;
  logic [1:0]       lvl_q;
  logic [NFLAG-1:0] flag_q, seen_q, flag_set, flag_clr;

  logic [CNT_W-1:0]  cnt, load_val;
  logic [CNT_W-1:0]  cmp [2];
  logic [1:0]        match, pin;
  logic [2:0]        load;
  logic              wrap, ctrl_we, stat_we, stat_re;
  logic [BYTE_W-1:0] ctrl_rd, stat_rd;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CKS_W-1:0] = cks_q;
    ctrl_rd[CLR_A_BIT] = clr_a_q;
    ctrl_rd[LVL_A_BIT] = lvl_q[0];
    ctrl_rd[LVL_B_BIT] = lvl_q[1];
    stat_rd = '0;
    stat_rd[NFLAG-1:0] = flag_q;
  end

  frt_bus u_bus (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .cnt_i(cnt), .cmp_a_i(cmp[0]), .cmp_b_i(cmp[1]),
    .ctrl_rd_i(ctrl_rd), .stat_rd_i(stat_rd), .rdata_o(bus_rdata_o),
    .load_o(load), .load_val_o(load_val),
    .ctrl_we_o(ctrl_we), .stat_we_o(stat_we), .stat_re_o(stat_re)
  );

  frt_counter #(.NUM_TICK(NUM_TICK), .CKS_W(CKS_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .cks_i(cks_q),
    .load_i(load[0]), .load_val_i(load_val),
    .clr_i(clr_a_q & match[0]), .stby_i,
    .cnt_o(cnt), .wrap_o(wrap)
  );

  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : g_ch
      frt_cmp_ch u_ch (
        .clk_i, .rst_ni, .cnt_i(cnt),
        .load_i(load[c+1]), .load_val_i(load_val), .stby_i,
        .level_i(lvl_q[c]), .cmp_o(cmp[c]), .match_o(match[c]), .pin_o(pin[c])
      );
    end
  endgenerate

  assign cmp_a_o = pin[0];
  assign cmp_b_o = pin[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cks_q   <= '0;
      clr_a_q <= 1'b0;
      lvl_q   <= '0;
    end else if (ctrl_we) begin
      cks_q   <= bus_wdata_i[CKS_W-1:0];
      clr_a_q <= bus_wdata_i[CLR_A_BIT];
      lvl_q   <= {bus_wdata_i[LVL_B_BIT], bus_wdata_i[LVL_A_BIT]};
    end
  end

  // flags: clear needs a prior read of 1, a new set wins
  always_comb begin
    flag_set            = '0;
    flag_set[F_MATCH_A] = match[0];
    flag_set[F_MATCH_B] = match[1];
    flag_set[F_WRAP]    = wrap;
    flag_clr = stat_we ? (seen_q & ~bus_wdata_i[NFLAG-1:0]) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      seen_q <= '0;
    end else begin
      flag_q <= flag_set | (flag_q & ~flag_clr);
      if (stat_re)      seen_q <= flag_q;
      else if (stat_we) seen_q <= '0;
    end
  end

  assert_ovf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q[F_WRAP]);
  assert_match_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[0] |=> flag_q[F_MATCH_A]);
  assert_match_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[1] |=> flag_q[F_MATCH_B]);
  assert_clr_needs_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[F_WRAP] && !seen_q[F_WRAP]) |=> flag_q[F_WRAP]);
endmodule

// File: tb/tb_frt_dual_cmp.sv
module tb_frt_dual_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stby = 1'b0;
  logic [3:0] tick = '0;
  logic       sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       out_a, out_b;

  int checks = 0, errors = 0;
  bit force_tick = 1'b0;

  always #4 clk = ~clk;

  frt_dual_cmp dut (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby), .tick_i(tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wd),
    .bus_rdata_o(rdata), .cmp_a_o(out_a), .cmp_b_o(out_b)
  );

  // reference state from the requirements
  logic [15:0] m_cnt, m_cpa, m_cpb;
  logic [7:0]  m_tmp;
  logic [1:0]  m_cks;
  logic        m_cclr, m_lvla, m_lvlb, m_pa, m_pb;
  logic [2:0]  m_flags, m_seen;

  always @(posedge clk or negedge rst_n) begin
    logic step, ma, mb, clra, wrap, wr, rd;
    logic [15:0] nc;
    logic [2:0]  clr;
    if (!rst_n) begin
      m_cnt = 16'h0000; m_cpa = 16'hFFFF; m_cpb = 16'hFFFF; m_tmp = '0;
      m_cks = '0; m_cclr = 0; m_lvla = 0; m_lvlb = 0; m_pa = 0; m_pb = 0;
      m_flags = '0; m_seen = '0;
    end else begin
      wr = sel & we; rd = sel & ~we;
      step = tick[m_cks];
      ma = m_cnt == m_cpa; mb = m_cnt == m_cpb;
      clra = m_cclr & ma;
      nc = m_cnt;
      if (stby) nc = 16'h0;
      else if (wr && addr == 3) nc = {m_tmp, wd};
      else if (clra) nc = 16'h0;
      else if (step) nc = m_cnt + 16'd1;
      wrap = step && !stby && !(wr && addr == 3) && !clra && m_cnt == 16'hFFFF;
      clr = (wr && addr == 1) ? (m_seen & ~wd[2:0]) : 3'b0;
      if (ma) m_pa = m_lvla;
      if (mb) m_pb = m_lvlb;
      if (rd && addr == 1) m_seen = m_flags;
      else if (wr && addr == 1) m_seen = '0;
      m_flags = {wrap, mb, ma} | (m_flags & ~clr);
      if (stby) begin m_cpa = 16'hFFFF; m_cpb = 16'hFFFF; end
      else begin
        if (wr && addr == 5) m_cpa = {m_tmp, wd};
        if (wr && addr == 7) m_cpb = {m_tmp, wd};
      end
      if (wr && addr == 0) begin
        m_cks = wd[1:0]; m_cclr = wd[2]; m_lvla = wd[3]; m_lvlb = wd[4];
      end
      if (wr && addr >= 2 && !addr[0]) m_tmp = wd;
      else if (rd && addr == 2) m_tmp = m_cnt[7:0];
      else if (rd && addr == 4) m_tmp = m_cpa[7:0];
      else if (rd && addr == 6) m_tmp = m_cpb[7:0];
      m_cnt = nc;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_lvlb, m_lvla, m_cclr, m_cks};
      3'd1: return {5'b0, m_flags};
      3'd2: return m_cnt[15:8];
      3'd4: return m_cpa[15:8];
      3'd6: return m_cpb[15:8];
      default: return m_tmp;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                     input logic [7:0] d, input logic sb, input string tag);
    @(negedge clk);
    sel = s; we = w; addr = a; wd = d; stby = sb;
    tick = force_tick ? 4'hF : 4'($urandom);
    #1;
    if (s && !w) check(tag, {8'h0, rdata}, {8'h0, exp_rd(a)});
    check("R6 pins", {14'h0, out_b, out_a}, {14'h0, m_pb, m_pa});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 8'h0, 0, "R2");
  endtask

  task automatic rd16(input logic [2:0] hi, input string tag);
    cyc(1, 0, hi, 8'h0, 0, tag);
    cyc(1, 0, hi + 3'd1, 8'h0, 0, tag);
  endtask

  task automatic wr16(input logic [2:0] hi, input logic [15:0] v, input string tag);
    cyc(1, 1, hi, v[15:8], 0, tag);
    cyc(1, 1, hi + 3'd1, v[7:0], 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values through the bus
    cyc(1, 0, 3'd0, 8'h0, 0, "R1 ctrl");
    cyc(1, 0, 3'd1, 8'h0, 0, "R1 status");
    check("R1 pins", {14'h0, out_b, out_a}, 16'h0);
    force_tick = 1'b1;
    rd16(3'd4, "R1 cmpA");
    rd16(3'd6, "R1 cmpB");
    rd16(3'd2, "R7 cnt atomic");
    // R4 clear on match A, R6 level A high
    wr16(3'd4, 16'h0010, "R8 cmpA");
    cyc(1, 1, 3'd0, 8'b0000_1100, 0, "R4 ctrl");
    idle(40);
    rd16(3'd2, "R4 cnt");
    check("R6 pin A high", {15'h0, out_a}, 16'h1);
    cyc(1, 0, 3'd1, 8'h0, 0, "R5 status");
    cyc(1, 1, 3'd1, 8'h00, 0, "R9 clear");
    cyc(1, 0, 3'd1, 8'h0, 0, "R9 status");
    // R3 overflow and R9 write without prior read
    cyc(1, 1, 3'd0, 8'h00, 0, "R3 ctrl");
    wr16(3'd2, 16'hFFFD, "R8 cnt");
    idle(5);
    cyc(1, 0, 3'd1, 8'h0, 0, "R3 status");
    cyc(1, 1, 3'd1, 8'h0, 0, "R9 status");
    cyc(1, 1, 3'd1, 8'h0, 0, "R9 unread write");
    cyc(1, 0, 3'd1, 8'h0, 0, "R9 kept");
    // R10 standby
    wr16(3'd6, 16'h1234, "R8 cmpB");
    cyc(0, 0, 3'd0, 8'h0, 1, "R10");
    rd16(3'd2, "R10 cnt");
    rd16(3'd6, "R10 cmpB");
    force_tick = 1'b0;
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [2:0] hw;
      k = $urandom_range(0, 6);
      hw = 3'(2 * $urandom_range(1, 3));
      case (k)
        0: rd16(hw, "R7 rand");
        1: wr16(hw, {($urandom_range(0, 3) == 0) ? 8'hFF : 8'h00, 8'($urandom)}, "R8 rand");
        2: cyc(1, 1, 3'd0, 8'($urandom), 0, "R2 rand ctrl");
        3: begin
          cyc(1, 0, 3'd1, 8'h0, 0, "R5 rand");
          cyc(1, 1, 3'd1, 8'($urandom), 0, "R9 rand");
        end
        4: idle($urandom_range(1, 20));
        5: cyc(0, 0, 3'd0, 8'h0, ($urandom_range(0, 9) == 0), "R10 rand");
        default: cyc(1, 0, 3'($urandom), 8'h0, 0, "R7 rand read");
      endcase
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule